// File: doc/BRIEF.md
# Crossbar Partition-Search Read Sequencer

This block is a digital controller that recovers the full contents of an N x N resistive crossbar, with N a power of two. It does not visit the cells one at a time. It narrows the search by halving regions. Every descriptor cycle it presents two rectangular segments, each given as a base row, base column, height and width, plus a flag that says which lines are driven. Two threshold detectors answer one cycle later with one bit per segment. The bit says whether the segment carries enough current to contain at least one conducting cell.

A square region is handled in a round of up to three descriptor cycles. In the first cycle it is cut into upper and lower halves, with the rows driven. Next the upper half is cut into left and right quadrants, with the columns driven. Then the lower half is cut the same way. A half or quadrant that reports no current is left at zero in the result bitmap and is not examined again. A quadrant of size greater than one that reports current goes onto a LIFO worklist. A 1 x 1 quadrant has its detector bit written straight into the bitmap. When the worklist runs dry the block pulses done, and software reads the bitmap one row per address.

Top module: `xbar_search_rd`

## Requirements
- R1: When a run has finished, driving rd_row_i = r makes rd_data_o[c] equal to the state of cell (r, c), where 1 means low-resistance (conducting) and 0 means high-resistance.
- R2: After reset the block is idle: busy_o, done_o and seg_valid_o are 0, and every bitmap row reads as zero.
- R3: The first descriptor cycle after an accepted start has seg_dir_o = 0 (rows driven, columns sensed). Segment A covers rows 0..N/2-1 over all N columns, and segment B covers rows N/2..N-1 over all N columns.
- R4: A vertical split has seg_dir_o = 1 (columns driven, rows sensed). Its two segments are square, each half the size of the region, share a base row, and B starts where A ends in the column direction.
- R5: Within a round, the horizontal cut comes first, then the upper-half vertical cut, then the lower-half vertical cut.
- R6: A half or quadrant that reports 0 is never split further. An all-zero array finishes after exactly one descriptor cycle, and an array with one conducting cell finishes after exactly 2*log2(N) descriptor cycles.
- R7: Every descriptor cycle is followed by exactly one non-descriptor cycle, and the detector bits are taken in that following cycle.
- R8: For a 1 x 1 quadrant the detector bit is stored directly. An all-ones array therefore needs exactly N*N-1 descriptor cycles.
- R9: done_o is a single-cycle pulse, and busy_o is already low in that cycle.
- R10: A start_i pulse while busy_o is high has no effect on the descriptor sequence or the result.
- R11: An accepted start clears the bitmap left by the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a read of the whole array (accepted when idle) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| seg_valid_o | output | 1 | Segment descriptors valid this cycle |
| seg_dir_o | output | 1 | 0: rows driven, columns sensed; 1: columns driven, rows sensed |
| seg_a_row_o | output | log2(N) | Segment A base row |
| seg_a_col_o | output | log2(N) | Segment A base column |
| seg_a_h_o | output | log2(N)+1 | Segment A height |
| seg_a_w_o | output | log2(N)+1 | Segment A width |
| seg_b_row_o | output | log2(N) | Segment B base row |
| seg_b_col_o | output | log2(N) | Segment B base column |
| seg_b_h_o | output | log2(N)+1 | Segment B height |
| seg_b_w_o | output | log2(N)+1 | Segment B width |
| det_a_i | input | 1 | Detector answer for segment A, one cycle after the descriptor |
| det_b_i | input | 1 | Detector answer for segment B, one cycle after the descriptor |
| rd_row_i | input | log2(N) | Bitmap row to read |
| rd_data_o | output | N | Bitmap row contents, bit c is column c |

## Verification
A corrupted worklist entry or a wrong quadrant offset shows up at the descriptor ports within one round. It appears as a segment geometry that does not tile its parent, or as a descriptor count that differs from the closed-form totals for empty, single-cell and full arrays. A wrong leaf write or a missed push becomes visible only after done, as a bitmap row that differs from the modelled array. So every run ends with a full row-by-row readback. A stale flag that selects the wrong vertical cut changes the descriptor order in the same round, so the order is checked directly on the cycles after start.

// File: rtl/xbar_search_pkg.sv
package xbar_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_H_DRV,
    ST_H_WAIT,
    ST_U_DRV,
    ST_U_WAIT,
    ST_L_DRV,
    ST_L_WAIT
  } st_e;

  localparam logic DIR_ROWS = 1'b0;
  localparam logic DIR_COLS = 1'b1;
endpackage

// File: rtl/xbar_worklist.sv
module xbar_worklist #(
  parameter int EW    = 10,
  parameter int DEPTH = 12,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            pop_i,
  input  logic            push_a_i,
  input  logic [EW-1:0]   push_a_d_i,
  input  logic            push_b_i,
  input  logic [EW-1:0]   push_b_d_i,
  output logic [EW-1:0]   top_o,
  output logic [CNTW-1:0] cnt_o
);
  logic [EW-1:0]   mem [DEPTH];
  logic [CNTW-1:0] sp, base, idx_a, idx_b;

  always_comb begin
    if (clr_i)                      base = '0;
    else if (pop_i && sp != '0)     base = sp - 1'b1;
    else                            base = sp;
    idx_a = base;
    idx_b = base + CNTW'(push_a_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp <= '0;
    else         sp <= base + CNTW'(push_a_i) + CNTW'(push_b_i);
  end

  always_ff @(posedge clk_i) begin
    if (push_a_i && idx_a < CNTW'(DEPTH)) mem[idx_a] <= push_a_d_i;
    if (push_b_i && idx_b < CNTW'(DEPTH)) mem[idx_b] <= push_b_d_i;
  end

  assign top_o = (sp == '0) ? '0 : mem[sp - 1'b1];
  assign cnt_o = sp;
endmodule

// File: rtl/xbar_bitmap.sv
module xbar_bitmap #(
  parameter int N  = 8,
  localparam int CW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_a_i,
  input  logic [CW-1:0] row_a_i,
  input  logic [CW-1:0] col_a_i,
  input  logic          bit_a_i,
  input  logic          we_b_i,
  input  logic [CW-1:0] row_b_i,
  input  logic [CW-1:0] col_b_i,
  input  logic          bit_b_i,
  input  logic [CW-1:0] rd_row_i,
  output logic [N-1:0]  rd_data_o
);
  logic [N-1:0] rows_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++) rows_q[r] <= '0;
    end else if (clr_i) begin
      for (int r = 0; r < N; r++) rows_q[r] <= '0;
    end else begin
      if (we_a_i) rows_q[row_a_i][col_a_i] <= bit_a_i;
      if (we_b_i) rows_q[row_b_i][col_b_i] <= bit_b_i;
    end
  end

  assign rd_data_o = rows_q[rd_row_i];
endmodule

// File: rtl/xbar_seg_gen.sv
module xbar_seg_gen
  import xbar_search_pkg::*;
#(
  parameter int CW = 3,
  localparam int SW = CW + 1
) (
  input  st_e           st_i,
  input  logic [CW-1:0] reg_row_i,
  input  logic [CW-1:0] reg_col_i,
  input  logic [SW-1:0] reg_size_i,
  output logic          valid_o,
  output logic          dir_o,
  output logic [CW-1:0] a_row_o,
  output logic [CW-1:0] a_col_o,
  output logic [SW-1:0] a_h_o,
  output logic [SW-1:0] a_w_o,
  output logic [CW-1:0] b_row_o,
  output logic [CW-1:0] b_col_o,
  output logic [SW-1:0] b_h_o,
  output logic [SW-1:0] b_w_o
);
  logic [CW-1:0] half_c;
  logic [SW-1:0] half_s;

  assign half_c = reg_size_i[SW-1:1];
  assign half_s = {1'b0, half_c};

  always_comb begin
    valid_o = 1'b0;
    dir_o   = DIR_ROWS;
    a_row_o = '0; a_col_o = '0; a_h_o = '0; a_w_o = '0;
    b_row_o = '0; b_col_o = '0; b_h_o = '0; b_w_o = '0;
    unique case (st_i)
      ST_H_DRV: begin
        valid_o = 1'b1;
        a_row_o = reg_row_i;          a_col_o = reg_col_i;
        b_row_o = reg_row_i + half_c; b_col_o = reg_col_i;
        a_h_o = half_s; a_w_o = reg_size_i;
        b_h_o = half_s; b_w_o = reg_size_i;
      end
      ST_U_DRV, ST_L_DRV: begin
        valid_o = 1'b1;
        dir_o   = DIR_COLS;
        a_row_o = (st_i == ST_L_DRV) ? reg_row_i + half_c : reg_row_i;
        b_row_o = a_row_o;
        a_col_o = reg_col_i;
        b_col_o = reg_col_i + half_c;
        a_h_o = half_s; a_w_o = half_s;
        b_h_o = half_s; b_w_o = half_s;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbar_search_rd.sv
module xbar_search_rd
  import xbar_search_pkg::*;
#(
  parameter int N = 8,
  localparam int CW    = $clog2(N),
  localparam int SW    = CW + 1,
  localparam int EW    = 2 * CW + SW,
  localparam int DEPTH = 4 * CW,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          seg_valid_o,
  output logic          seg_dir_o,
  output logic [CW-1:0] seg_a_row_o,
  output logic [CW-1:0] seg_a_col_o,
  output logic [SW-1:0] seg_a_h_o,
  output logic [SW-1:0] seg_a_w_o,
  output logic [CW-1:0] seg_b_row_o,
  output logic [CW-1:0] seg_b_col_o,
  output logic [SW-1:0] seg_b_h_o,
  output logic [SW-1:0] seg_b_w_o,
  input  logic          det_a_i,
  input  logic          det_b_i,
  input  logic [CW-1:0] rd_row_i,
  output logic [N-1:0]  rd_data_o
);
  st_e st_q, st_d;
  logic [CW-1:0] cur_row, cur_col;
  logic [SW-1:0] cur_size;
  logic          lo_hit_q, done_q;

  logic [EW-1:0]   wl_top, push_a_d, push_b_d;
  logic [CNTW-1:0] wl_cnt;
  logic            start_ok, in_vwait, leaf, push_a, push_b, empty_after, finish;
  logic [CW-1:0]   half_c, q_row, top_row, top_col;
  logic [SW-1:0]   top_size;
  logic [CW-1:0]   g_row, g_col;
  logic [SW-1:0]   g_size;

  assign top_row  = wl_top[EW-1 -: CW];
  assign top_col  = wl_top[SW +: CW];
  assign top_size = wl_top[SW-1:0];

  assign start_ok = (st_q == ST_IDLE) && start_i;
  assign in_vwait = (st_q == ST_U_WAIT) || (st_q == ST_L_WAIT);
  assign half_c   = cur_size[SW-1:1];
  assign leaf     = (cur_size == SW'(2));
  assign q_row    = (st_q == ST_L_WAIT) ? cur_row + half_c : cur_row;

  assign push_a   = start_ok || (in_vwait && !leaf && det_a_i);
  assign push_b   = in_vwait && !leaf && det_b_i;
  assign push_a_d = start_ok ? {CW'(0), CW'(0), SW'(N)} : {q_row, cur_col, 1'b0, half_c};
  assign push_b_d = {q_row, cur_col + half_c, 1'b0, half_c};
  assign empty_after = (wl_cnt == '0) && !push_a && !push_b;

  xbar_worklist #(.EW(EW), .DEPTH(DEPTH)) i_worklist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .pop_i     (st_q == ST_H_DRV),
    .push_a_i  (push_a),
    .push_a_d_i(push_a_d),
    .push_b_i  (push_b),
    .push_b_d_i(push_b_d),
    .top_o     (wl_top),
    .cnt_o     (wl_cnt)
  );

  xbar_bitmap #(.N(N)) i_bitmap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok),
    .we_a_i   (in_vwait && leaf),
    .row_a_i  (q_row),
    .col_a_i  (cur_col),
    .bit_a_i  (det_a_i),
    .we_b_i   (in_vwait && leaf),
    .row_b_i  (q_row),
    .col_b_i  (cur_col + half_c),
    .bit_b_i  (det_b_i),
    .rd_row_i (rd_row_i),
    .rd_data_o(rd_data_o)
  );

  // H_DRV works on the entry still on top of the list; later phases on the latched region
  assign g_row  = (st_q == ST_H_DRV) ? top_row  : cur_row;
  assign g_col  = (st_q == ST_H_DRV) ? top_col  : cur_col;
  assign g_size = (st_q == ST_H_DRV) ? top_size : cur_size;

  xbar_seg_gen #(.CW(CW)) i_seg_gen (
    .st_i      (st_q),
    .reg_row_i (g_row),
    .reg_col_i (g_col),
    .reg_size_i(g_size),
    .valid_o   (seg_valid_o),
    .dir_o     (seg_dir_o),
    .a_row_o   (seg_a_row_o),
    .a_col_o   (seg_a_col_o),
    .a_h_o     (seg_a_h_o),
    .a_w_o     (seg_a_w_o),
    .b_row_o   (seg_b_row_o),
    .b_col_o   (seg_b_col_o),
    .b_h_o     (seg_b_h_o),
    .b_w_o     (seg_b_w_o)
  );

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_H_DRV;
      ST_H_DRV:  st_d = ST_H_WAIT;
      ST_H_WAIT: begin
        if (det_a_i)          st_d = ST_U_DRV;
        else if (det_b_i)     st_d = ST_L_DRV;
        else if (empty_after) finish = 1'b1;
        else                  st_d = ST_H_DRV;
      end
      ST_U_DRV:  st_d = ST_U_WAIT;
      ST_U_WAIT: begin
        if (lo_hit_q)         st_d = ST_L_DRV;
        else if (empty_after) finish = 1'b1;
        else                  st_d = ST_H_DRV;
      end
      ST_L_DRV:  st_d = ST_L_WAIT;
      ST_L_WAIT: begin
        if (empty_after)      finish = 1'b1;
        else                  st_d = ST_H_DRV;
      end
      default:   st_d = ST_IDLE;
    endcase
    if (finish) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cur_row  <= '0;
      cur_col  <= '0;
      cur_size <= '0;
      lo_hit_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (st_q == ST_H_DRV) begin
        cur_row  <= top_row;
        cur_col  <= top_col;
        cur_size <= top_size;
      end
      if (st_q == ST_H_WAIT) lo_hit_q <= det_b_i;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/xbar_search_chk.sv
module xbar_search_chk #(
  parameter int N = 8,
  localparam int CW    = $clog2(N),
  localparam int SW    = CW + 1,
  localparam int DEPTH = 4 * CW,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            seg_valid_o,
  input logic            seg_dir_o,
  input logic [CW-1:0]   seg_a_row_o,
  input logic [CW-1:0]   seg_a_col_o,
  input logic [SW-1:0]   seg_a_h_o,
  input logic [SW-1:0]   seg_a_w_o,
  input logic [CW-1:0]   seg_b_row_o,
  input logic [CW-1:0]   seg_b_col_o,
  input logic [CNTW-1:0] wl_cnt
);
  logic [CW-1:0] a_h_c, a_w_c;
  assign a_h_c = seg_a_h_o[CW-1:0];
  assign a_w_c = seg_a_w_o[CW-1:0];

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !seg_valid_o); // R2
  AST_FIRST_HSPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (seg_valid_o && !seg_dir_o && seg_a_row_o == '0 &&
      seg_a_h_o == SW'(N/2) && seg_a_w_o == SW'(N) && seg_b_row_o == CW'(N/2))); // R3
  AST_HSPLIT_TILES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && !seg_dir_o) |-> (seg_b_row_o == seg_a_row_o + a_h_c &&
      seg_b_col_o == seg_a_col_o && seg_a_w_o == (seg_a_h_o << 1))); // R3
  AST_VSPLIT_TILES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && seg_dir_o) |-> (seg_b_col_o == seg_a_col_o + a_w_c &&
      seg_b_row_o == seg_a_row_o && seg_a_h_o == seg_a_w_o)); // R4
  AST_WAIT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |=> (busy_o && !seg_valid_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !seg_valid_o)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_cnt <= CNTW'(DEPTH)); // R1
endmodule

bind xbar_search_rd xbar_search_chk #(.N(N)) i_xbar_search_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .seg_valid_o(seg_valid_o),
  .seg_dir_o  (seg_dir_o),
  .seg_a_row_o(seg_a_row_o),
  .seg_a_col_o(seg_a_col_o),
  .seg_a_h_o  (seg_a_h_o),
  .seg_a_w_o  (seg_a_w_o),
  .seg_b_row_o(seg_b_row_o),
  .seg_b_col_o(seg_b_col_o),
  .wl_cnt     (wl_cnt)
);

// File: tb/test_xbar_search_rd.sv
module test_xbar_search_rd;
  localparam int N      = 8;
  localparam int CW     = $clog2(N);
  localparam int SW     = CW + 1;
  localparam int PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, seg_valid_o, seg_dir_o;
  logic [CW-1:0] seg_a_row_o, seg_a_col_o, seg_b_row_o, seg_b_col_o;
  logic [SW-1:0] seg_a_h_o, seg_a_w_o, seg_b_h_o, seg_b_w_o;
  logic det_a_i = 1'b0, det_b_i = 1'b0;
  logic [CW-1:0] rd_row_i = '0;
  logic [N-1:0]  rd_data_o;

  logic [N-1:0] cells [N];
  int n_chk = 0, n_fail = 0;
  int desc_total = 0, b2b_total = 0;
  logic prev_valid = 1'b0;
  bit summary_done = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  xbar_search_rd #(.N(N)) i_xbar_search_rd (.*);

  function automatic logic any_set(logic [CW-1:0] r0, logic [CW-1:0] c0,
                                   logic [SW-1:0] h, logic [SW-1:0] w);
    logic hit = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (r >= int'(r0) && r < int'(r0) + int'(h) &&
            c >= int'(c0) && c < int'(c0) + int'(w) && cells[r][c]) hit = 1'b1;
    return hit;
  endfunction

  // array model: detector answers one cycle after the descriptors
  always @(posedge clk_i) begin
    if (seg_valid_o) begin
      det_a_i <= any_set(seg_a_row_o, seg_a_col_o, seg_a_h_o, seg_a_w_o);
      det_b_i <= any_set(seg_b_row_o, seg_b_col_o, seg_b_h_o, seg_b_w_o);
      desc_total <= desc_total + 1;
    end
    if (seg_valid_o && prev_valid) b2b_total <= b2b_total + 1;
    prev_valid <= seg_valid_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic fill(input int kind, input int seed);
    int s = seed;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
        case (kind)
          0: cells[r][c] = 1'b0;
          1: cells[r][c] = 1'b1;
          default: cells[r][c] = (s[7:4] == 4'h3) || (s[7:4] == 4'hA);
        endcase
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  // waits for done; returns descriptor cycles counted since start_snap
  task automatic wait_done(input int start_snap, output int ndesc, input string req);
    int t = 0;
    while (!done_o && t < 5000) begin @(negedge clk_i); t++; end
    chk(done_o == 1'b1, req, "done reached", done_o, 1);
    chk(busy_o == 1'b0, "R9", "busy low with done", busy_o, 0);
    ndesc = desc_total - start_snap;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9", "done one cycle", done_o, 0);
  endtask

  task automatic check_map(input string req);
    for (int r = 0; r < N; r++) begin
      @(negedge clk_i); rd_row_i = CW'(r);
      #1;
      chk(rd_data_o == cells[r], req, $sformatf("row %0d", r), rd_data_o, cells[r]);
    end
  endtask

  task automatic run(output int ndesc, input string req);
    int snap;
    @(negedge clk_i); snap = desc_total; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    wait_done(snap, ndesc, req);
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0 && done_o == 1'b0, "R2", "idle flags", {busy_o, done_o}, 0);
    chk(seg_valid_o == 1'b0, "R2", "no descriptors", seg_valid_o, 0);
    check_map("R2");
  endtask

  task automatic t_full();
    int snap, nd;
    fill(1, 1);
    @(negedge clk_i); snap = desc_total; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(seg_valid_o && !seg_dir_o, "R3", "first step horizontal", {seg_valid_o, seg_dir_o}, 2);
    chk(seg_a_row_o == 0 && seg_a_col_o == 0 && seg_a_h_o == N/2 && seg_a_w_o == N,
        "R3", "upper half", {seg_a_row_o, seg_a_col_o, seg_a_h_o, seg_a_w_o},
        {CW'(0), CW'(0), SW'(N/2), SW'(N)});
    chk(seg_b_row_o == N/2 && seg_b_col_o == 0 && seg_b_h_o == N/2 && seg_b_w_o == N,
        "R3", "lower half", {seg_b_row_o, seg_b_col_o, seg_b_h_o, seg_b_w_o},
        {CW'(N/2), CW'(0), SW'(N/2), SW'(N)});
    @(negedge clk_i);
    chk(seg_valid_o == 1'b0, "R7", "wait slot", seg_valid_o, 0);
    @(negedge clk_i);
    chk(seg_valid_o && seg_dir_o && seg_a_row_o == 0 && seg_a_col_o == 0 &&
        seg_b_row_o == 0 && seg_b_col_o == N/2 && seg_a_h_o == N/2 && seg_b_w_o == N/2,
        "R4", "upper vertical split", {seg_dir_o, seg_a_row_o, seg_b_col_o, seg_a_h_o},
        {1'b1, CW'(0), CW'(N/2), SW'(N/2)});
    @(negedge clk_i);
    @(negedge clk_i);
    chk(seg_valid_o && seg_dir_o && seg_a_row_o == N/2 && seg_a_col_o == 0 &&
        seg_b_row_o == N/2 && seg_b_col_o == N/2, "R5", "lower split after upper",
        {seg_a_row_o, seg_b_col_o}, {CW'(N/2), CW'(N/2)});
    wait_done(snap, nd, "R8");
    chk(nd == N*N - 1, "R8", "descriptor cycles full array", nd, N*N - 1);
    chk(b2b_total == 0, "R7", "back-to-back descriptors", b2b_total, 0);
    check_map("R1");
  endtask

  task automatic t_empty_after_full();
    int nd;
    fill(0, 1);
    run(nd, "R6");
    chk(nd == 1, "R6", "descriptor cycles empty array", nd, 1);
    check_map("R11");
  endtask

  task automatic t_single();
    int nd;
    fill(0, 1);
    cells[5][2] = 1'b1;
    run(nd, "R6");
    chk(nd == 2 * CW, "R6", "descriptor cycles one cell", nd, 2 * CW);
    check_map("R8");
  endtask

  task automatic t_random(input int seed);
    int nd;
    fill(2, seed);
    run(nd, "R1");
    check_map("R1");
  endtask

  task automatic t_start_busy();
    int nd_ref, nd, snap;
    fill(2, 77);
    run(nd_ref, "R10");
    @(negedge clk_i); snap = desc_total; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(busy_o == 1'b1, "R10", "busy at restart attempt", busy_o, 1);
    start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    wait_done(snap, nd, "R10");
    chk(nd == nd_ref, "R10", "descriptor count unchanged", nd, nd_ref);
    check_map("R10");
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_full();
    t_empty_after_full();
    t_single();
    t_random(12345);
    t_random(987);
    t_random(4242);
    t_start_busy();
    summary();
    $finish;
  end
endmodule